// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is an indexed bank of configuration registers inside a multi-function peripheral controller. The host reaches it through two ports. It first writes a register number into the index port. It then reads or writes that register through the data port. An access of either kind takes effect only while the configuration-mode input is high. The logic that raises and lowers that input lies outside this block.

Two registers are implemented. Register 01h holds the parallel-port power enable, the parallel-port mode select and a one-way lock bit. Register 02h holds the power enables of two serial ports. Reserved bits always read fixed values. When software writes 0 to the lock bit, the registers in the range 00h–0Fh can no longer be read or written. Only a reset clears that state. The register bits drive the block's power and mode outputs directly, and these outputs act on the devices and their pins. They do not act on the address-range registers of those devices.

Top module: `cfg_reg_bank`

## Requirements
- R1: After a synchronous active-low reset, register 01h reads 9Ch, register 02h reads 88h, and all four outputs are 1.
- R2: While `cfg_mode` is 0, writes to either port change nothing and reads return 00h.
- R3: The data port accesses the register whose number was last written to the index port (`port_sel`=0 selects the index port, 1 selects the data port). A read of the index port returns the stored index.
- R4: In register 01h, bits 0, 1, 5 and 6 always read 0 and bit 4 always reads 1. Writes to these bits are ignored.
- R5: Register 01h bit 2 drives `par_power_on` (1 = powered, 0 = low power). Register 01h bit 3 drives `par_printer_mode` (1 = printer mode, 0 = extended modes).
- R6: Register 02h bit 3 drives `ser0_power_on` and bit 7 drives `ser1_power_on` (1 = running, 0 = powered down). All other bits of register 02h read 0.
- R7: A write with bit 7 = 0 to register 01h sets the lock. While locked, reads of registers 00h–0Fh return 00h and writes to them are dropped, so the outputs hold their values.
- R8: Once set, the lock cannot be cleared by any write. Only a reset clears it.
- R9: While locked, the index port can still be written and read back.
- R10: An index that selects no implemented register reads 00h, and a write to it alters no register.
- R11: An accepted data write changes the outputs at the clock edge that captures it and never before. The outputs do not change in cycles that have no accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode; accesses take effect only while it is high |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; the result appears on `rdata` in the same cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 00h when no read is accepted |
| par_power_on | output | 1 | Parallel port power enable |
| par_printer_mode | output | 1 | Parallel port printer-mode select |
| ser0_power_on | output | 1 | Primary serial port power enable |
| ser1_power_on | output | 1 | Secondary serial port power enable |

## Verification
Several properties are checked on every cycle:
- the lock, once set, stays set;
- the index holds unless an index write is accepted;
- reserved bits keep their fixed values;
- reads outside configuration mode, and reads of the locked range, return zero;
- the outputs hold in any cycle with no accepted data write.

The bench scenarios show the rest:
- the reset values;
- how a write maps onto register bits and then onto each output;
- that a write is dropped when it goes to an unimplemented register, comes outside configuration mode or comes after locking;
- that only a reset clears the lock.

// File: rtl/cfgbank_pkg.sv
// Package: shared constants for the configuration register bank.
// Holds the register descriptor tables (address, reset value, writable mask,
// fixed-one mask), the lock location and the output bit positions.
package cfgbank_pkg;

    localparam int DW       = 8;
    localparam int IW       = 8;
    localparam int NUM_REGS = 2;

    // Descriptor tables, one entry per implemented register
    localparam logic [7:0] REG_ADDR  [NUM_REGS] = '{8'h01, 8'h02};
    localparam logic [7:0] REG_RESET [NUM_REGS] = '{8'h9C, 8'h88};
    localparam logic [7:0] REG_WMASK [NUM_REGS] = '{8'h0C, 8'h88};
    localparam logic [7:0] REG_ONES  [NUM_REGS] = '{8'h10, 8'h00};

    // Lock bit location and the highest index it protects
    localparam int         LOCK_REG = 0;
    localparam int         LOCK_BIT = 7;
    localparam logic [7:0] LOCK_TOP = 8'h0F;

    // Output bit positions
    localparam int PAR_PWR_REG  = 0;
    localparam int PAR_PWR_BIT  = 2;
    localparam int PAR_MODE_REG = 0;
    localparam int PAR_MODE_BIT = 3;
    localparam int SER0_REG     = 1;
    localparam int SER0_BIT     = 3;
    localparam int SER1_REG     = 1;
    localparam int SER1_BIT     = 7;

    typedef enum logic {
        PORT_INDEX = 1'b0,
        PORT_DATA  = 1'b1
    } port_e;

endpackage

// File: rtl/cfg_index_reg.sv
// Module: cfg_index_reg
// Holds the register number that the host loaded through the index port.
// Assumes the caller has already qualified the write strobe with config mode;
// the lock never gates this register.
module cfg_index_reg #(
    parameter int IDX_W = cfgbank_pkg::IW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_in,
    output logic [IDX_W-1:0] idx_q
);

    // Capture a new index on each accepted index write
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (idx_wr)
            idx_q <= idx_in;
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(idx_q)); // R3

endmodule

// File: rtl/cfg_lock_ctl.sv
// Module: cfg_lock_ctl
// One-way lock flag. It starts open after reset, and a write of 0 to the lock
// bit closes it. No write can reopen it; only a reset can.
// Assumes lock_wr is asserted only for accepted data writes to the lock register.
module cfg_lock_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_wr,
    input  logic lock_wbit,
    output logic unlocked
);

    // Sticky clear: a write can only lower the flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked <= 1'b1;
        else if (lock_wr && !lock_wbit)
            unlocked <= 1'b0;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked == 1'b0) |=> (unlocked == 1'b0)); // R8

endmodule

// File: rtl/cfg_reg_file.sv
// Module: cfg_reg_file
// Storage for the implemented registers. The package descriptor tables set
// their number, addresses, reset values and masks. Writable bits are stored;
// fixed-one bits and the lock bit are merged in on read. Assumes wr_go is
// already qualified with config mode and the lock.
module cfg_reg_file
    import cfgbank_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int IDX_W  = IW,
    parameter int NREG   = NUM_REGS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       wr_go,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       unlocked,
    output logic [NREG-1:0][DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0]          rd_val
);

    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DATA_W-1:0] WM   = DATA_W'(REG_WMASK[g]);
        localparam logic [DATA_W-1:0] ONES = DATA_W'(REG_ONES[g]);
        localparam logic [DATA_W-1:0] RST  = DATA_W'(REG_RESET[g]);
        localparam logic [DATA_W-1:0] LKM  =
            (g == LOCK_REG) ? (DATA_W'(1) << LOCK_BIT) : '0;

        logic [DATA_W-1:0] store;
        logic [DATA_W-1:0] lock_part;

        assign hit[g] = (idx == IDX_W'(REG_ADDR[g]));

        // Update only the writable bits of the selected register
        always_ff @(posedge clk) begin
            if (!rst_n)
                store <= RST & WM;
            else if (wr_go && hit[g])
                store <= wdata & WM;
        end

        // Merge stored, fixed and lock bits into the visible value
        always_comb begin
            lock_part  = unlocked ? LKM : '0;
            reg_val[g] = store | ONES | lock_part;
        end

        AST_RSVD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
            ((reg_val[g] & ~(WM | ONES | LKM)) == '0) &&
            ((reg_val[g] & ONES) == ONES)); // R4
    end

    // Read mux: an index that matches no register yields zero
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i])
                rd_val = rd_val | reg_val[i];
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R10

endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank (top)
// Indexed configuration register bank with a one-way lock. The host writes an
// index, then reads or writes that register through the data port. Accesses
// count only while cfg_mode is high. Once locked, the range 00h..LOCK_TOP reads
// zero and ignores writes. Assumes rd_en and wr_en are one-cycle strobes.
module cfg_reg_bank
    import cfgbank_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int IDX_W  = IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              port_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              par_power_on,
    output logic              par_printer_mode,
    output logic              ser0_power_on,
    output logic              ser1_power_on
);

    logic [IDX_W-1:0]                idx;
    logic                            unlocked;
    logic [NUM_REGS-1:0][DATA_W-1:0] reg_val;
    logic [DATA_W-1:0]               rd_val;
    logic                            idx_wr;
    logic                            in_lock_range;
    logic                            data_ok;
    logic                            data_wr;
    logic                            lock_wr;

    // Qualify host strobes with config mode, port select and the lock
    always_comb begin
        idx_wr        = cfg_mode && wr_en && (port_sel == PORT_INDEX);
        in_lock_range = (idx <= IDX_W'(LOCK_TOP));
        data_ok       = cfg_mode && (port_sel == PORT_DATA) &&
                        !(!unlocked && in_lock_range);
        data_wr       = data_ok && wr_en;
        lock_wr       = data_wr && (idx == IDX_W'(REG_ADDR[LOCK_REG]));
    end

    cfg_index_reg #(.IDX_W(IDX_W)) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .idx_in (IDX_W'(wdata)),
        .idx_q  (idx)
    );

    cfg_lock_ctl u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_wr   (lock_wr),
        .lock_wbit (wdata[LOCK_BIT]),
        .unlocked  (unlocked)
    );

    cfg_reg_file #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NREG(NUM_REGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (idx),
        .wr_go    (data_wr),
        .wdata    (wdata),
        .unlocked (unlocked),
        .reg_val  (reg_val),
        .rd_val   (rd_val)
    );

    // Read return: index port, or the data port when access is permitted
    always_comb begin
        rdata = '0;
        if (cfg_mode && rd_en) begin
            if (port_sel == PORT_INDEX)
                rdata = DATA_W'(idx);
            else if (data_ok)
                rdata = rd_val;
        end
    end

    // Drive the power and mode outputs straight from the register bits
    always_comb begin
        par_power_on     = reg_val[PAR_PWR_REG][PAR_PWR_BIT];
        par_printer_mode = reg_val[PAR_MODE_REG][PAR_MODE_BIT];
        ser0_power_on    = reg_val[SER0_REG][SER0_BIT];
        ser1_power_on    = reg_val[SER1_REG][SER1_BIT];
    end

    AST_NO_CFG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> (rdata == '0)); // R2

    AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && cfg_mode && rd_en && port_sel && in_lock_range)
        |-> (rdata == '0)); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable({par_power_on, par_printer_mode,
                              ser0_power_on, ser1_power_on})); // R11

endmodule

// File: tb/cfg_reg_bank_test.sv
// Bench for cfg_reg_bank: one loop walks a vector table, then directed tests
// cover the outputs, config mode, the lock and reset.
module cfg_reg_bank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       port_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       par_power_on, par_printer_mode, ser0_power_on, ser1_power_on;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk; // 50 MHz

    cfg_reg_bank uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .port_sel(port_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .par_power_on(par_power_on), .par_printer_mode(par_printer_mode),
        .ser0_power_on(ser0_power_on), .ser1_power_on(ser1_power_on)
    );

    // Vector: {req[3:0], kind[1:0], data[7:0], expect[7:0]}
    // kind 0 = write index, 1 = write data, 2 = read index, 3 = read data
    localparam int NV = 20;
    localparam logic [21:0] VEC [NV] = '{
        {4'd3,  2'd0, 8'h01, 8'h00},
        {4'd1,  2'd3, 8'h00, 8'h9C},  // R1 reg 01h reset
        {4'd3,  2'd0, 8'h02, 8'h00},
        {4'd1,  2'd3, 8'h00, 8'h88},  // R1 reg 02h reset
        {4'd3,  2'd2, 8'h00, 8'h02},  // R3 index readback
        {4'd6,  2'd1, 8'hFF, 8'h00},
        {4'd6,  2'd3, 8'h00, 8'h88},  // R6 only bits 7,3 stick
        {4'd6,  2'd1, 8'h77, 8'h00},
        {4'd6,  2'd3, 8'h00, 8'h00},  // R6 others read 0
        {4'd3,  2'd0, 8'h01, 8'h00},
        {4'd4,  2'd1, 8'h80, 8'h00},
        {4'd4,  2'd3, 8'h00, 8'h90},  // R4 bit4 stays 1
        {4'd4,  2'd1, 8'hFF, 8'h00},
        {4'd4,  2'd3, 8'h00, 8'h9C},  // R4 bits 0,1,5,6 read 0
        {4'd10, 2'd0, 8'h05, 8'h00},
        {4'd10, 2'd3, 8'h00, 8'h00},  // R10 unimplemented reads 0
        {4'd10, 2'd1, 8'hFF, 8'h00},
        {4'd10, 2'd3, 8'h00, 8'h00},
        {4'd10, 2'd0, 8'h02, 8'h00},
        {4'd10, 2'd3, 8'h00, 8'h00}   // R10 reg 02h untouched
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        port_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        port_sel = sel; rd_en = 1'b1;
        #8 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] outs();
        return {4'h0, par_power_on, par_printer_mode, ser0_power_on, ser1_power_on};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        do_reset();
        check("R1", outs(), 8'h0F);  // R1 all outputs high
        cfg_mode = 1'b1;

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][17:16])
                2'd0: write(1'b0, VEC[i][15:8]);
                2'd1: write(1'b1, VEC[i][15:8]);
                2'd2: begin read(1'b0, r); check($sformatf("R%0d", VEC[i][21:18]), r, VEC[i][7:0]); end
                default: begin read(1'b1, r); check($sformatf("R%0d", VEC[i][21:18]), r, VEC[i][7:0]); end
            endcase
        end

        // Restore reg 02h, then exercise the outputs (R5, R6, R11)
        write(1'b1, 8'h88);
        check("R6", outs(), 8'h0F);
        write(1'b0, 8'h01);
        @(negedge clk);
        port_sel = 1'b1; wdata = 8'h90; wr_en = 1'b1;
        #2 check("R11", outs(), 8'h0F);       // before the edge: unchanged
        @(negedge clk); wr_en = 1'b0;
        check("R5", outs(), 8'h03);           // par bits now 0
        write(1'b0, 8'h02);
        write(1'b1, 8'h08);
        check("R6", outs(), 8'h02);           // ser0 on, ser1 off

        // Outside config mode nothing counts (R2)
        cfg_mode = 1'b0;
        write(1'b0, 8'h01);
        write(1'b1, 8'h88);
        check("R2", outs(), 8'h02);
        read(1'b1, r); check("R2", r, 8'h00);
        read(1'b0, r); check("R2", r, 8'h00);
        cfg_mode = 1'b1;
        read(1'b0, r); check("R2", r, 8'h02);

        // Lock (R7, R8, R9)
        write(1'b0, 8'h01);
        write(1'b1, 8'h0C);                   // lock, powers parallel port
        check("R7", outs(), 8'h0E);
        read(1'b1, r); check("R7", r, 8'h00);
        write(1'b1, 8'h80);                   // attempt to reopen
        read(1'b1, r); check("R8", r, 8'h00);
        write(1'b1, 8'h00);
        check("R7", outs(), 8'h0E);
        write(1'b0, 8'h02);
        read(1'b0, r); check("R9", r, 8'h02);
        write(1'b1, 8'h88);
        check("R7", outs(), 8'h0E);
        read(1'b1, r); check("R7", r, 8'h00);
        write(1'b0, 8'h10);
        read(1'b1, r); check("R10", r, 8'h00);

        // Only reset reopens the bank (R8)
        do_reset();
        check("R8", outs(), 8'h0F);
        write(1'b0, 8'h01);
        read(1'b1, r); check("R8", r, 8'h9C);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule